// File: doc/BRIEF.md
# Flash Thermometer-to-Binary Encoder

This block sits behind the comparator bank of a flash converter. It takes the 2^BITS-1 comparator decisions, which form a thermometer word whose ones fill upward from bit 0, and turns them into a BITS-bit binary level. A single comparator that lands on the wrong side, because of offset or an unsettled output, must not throw the result far from the true level.

Two encoding routes are built, and `gray_sel` picks one for each sample. In the row route, a three-tap majority vote cleans every thermometer bit against its two neighbours. A transition detector then lights at most one row, and the index of that row is the binary output. In the Gray route, every thermometer bit drives exactly one Gray bit through an XOR tree. The Gray word is registered, and a Gray-to-binary chain after that register forms the output. Each route registers the input word first and has its result at the output two clocks after the word is applied. The mode bit travels through the pipeline with its sample.

Top module: `flash_code_encoder`

## Requirements
- R1: While `rst_n` is low, `code_out` is 0. An asynchronous assertion of reset clears the output without waiting for a clock edge.
- R2: A word on `therm_in` that is sampled at clock edge k shows on `code_out` right after edge k+1. A new word is accepted at every edge.
- R3: With `gray_sel`=0, a clean thermometer word holding ones in bits 0 to c-1 and zeros above gives `code_out` = c, for every c from 0 to 2^BITS-1.
- R4: With `gray_sel`=1, a clean thermometer word gives `code_out` = c, its count of ones. For BITS=3, all ones gives 7 (Gray 100), ones in bits 0..5 give 6 (Gray 101), and all zeros give 0.
- R5: With `gray_sel`=0, let one bit be wrong in a clean word of count c, and let p be its 1-based position. The output is c when p <= c-2 or p >= c+3, c-1 when p is c-1 or c, and c+1 when p is c+1 or c+2. The vote treats the bit below bit 0 as 1 and the bit above the top as 0.
- R6: With `gray_sel`=1, Gray bit j is the XOR of the thermometer bits whose 1-based position p satisfies p mod 2^(j+1) = 2^j. A wrong bit at position p therefore flips only Gray bit tz(p), where tz is the count of trailing zeros. The output is the binary value of gray(c) XOR 2^tz(p).
- R7: The mode bit stays aligned with its sample. If `gray_sel` changes on every clock, each output is still decoded by the route that was selected for that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gray_sel | input | 1 | Route select for this sample: 1 = Gray route, 0 = voted row route |
| therm_in | input | 2^BITS-1 | Comparator decisions; bit 0 is the lowest reference level |
| code_out | output | BITS | Binary level, two clocks after its word |

## Verification
The route choice and a new sample meet in the same cycle. Each new word travels with its own mode bit while the previous word is still inside the pipeline, so a mode bit that were read one stage late would decode a word by the wrong route. This is provoked by changing `gray_sel` on every clock while a ramp of counts streams in. Each output is judged against the count of the word applied two clocks earlier. Single-bit faults are also streamed back to back with alternating modes, so the Gray XOR tree and the majority vote are both exercised with a neighbouring sample in the other route.

// File: rtl/flash_code_encoder.sv
module flash_code_encoder #(
  parameter int BITS = 3,
  localparam int LEVELS = (1 << BITS) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gray_sel,
  input  logic [LEVELS-1:0] therm_in,
  output logic [BITS-1:0]   code_out
);

  function automatic logic [LEVELS-1:0] tap_mask(input int j);
    logic [LEVELS-1:0] m;
    for (int p = 1; p <= LEVELS; p++)
      m[p-1] = ((p % (2 << j)) == (1 << j));
    return m;
  endfunction

  logic [LEVELS-1:0] therm_q;
  logic              sel_q1, sel_q2;
  logic [LEVELS+1:0] edge_ext;
  logic [LEVELS-1:0] voted;
  logic [LEVELS:0]   voted_ext;
  logic [LEVELS-1:0] rows;
  logic [BITS-1:0]   row_code, row_code_q;
  logic [BITS-1:0]   gray_d, gray_q, gray_bin;

  assign edge_ext  = {1'b0, therm_q, 1'b1};
  assign voted_ext = {1'b0, voted};

  for (genvar k = 0; k < LEVELS; k++) begin : g_level
    assign voted[k] = (edge_ext[k] & edge_ext[k+1]) |
                      (edge_ext[k+1] & edge_ext[k+2]) |
                      (edge_ext[k] & edge_ext[k+2]);
    assign rows[k]  = voted_ext[k] & ~voted_ext[k+1];
  end

  always_comb begin
    row_code = '0;
    for (int k = 0; k < LEVELS; k++)
      if (rows[k]) row_code = row_code | BITS'(k + 1);
  end

  for (genvar j = 0; j < BITS; j++) begin : g_gray
    assign gray_d[j]   = ^(therm_q & tap_mask(j));
    assign gray_bin[j] = ^gray_q[BITS-1:j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_q    <= '0;
      sel_q1     <= 1'b0;
      sel_q2     <= 1'b0;
      gray_q     <= '0;
      row_code_q <= '0;
    end else begin
      therm_q    <= therm_in;
      sel_q1     <= gray_sel;
      sel_q2     <= sel_q1;
      gray_q     <= gray_d;
      row_code_q <= row_code;
    end
  end

  assign code_out = sel_q2 ? gray_bin : row_code_q;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_q & (therm_q + LEVELS'(1))) == '0) |=> code_out == BITS'($countones($past(therm_q)))); // R3

  AST_GRAY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q1 && (&therm_q)) |=> (&code_out)); // R4

  AST_STEADY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $stable(therm_in) && $stable(gray_sel)) |-> ##2 $stable(code_out)); // R2

  AST_GRAY_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $countones(therm_q ^ $past(therm_q)) == 1) |=> $countones(gray_q ^ $past(gray_q)) == 1); // R6

endmodule

// File: tb/flash_code_encoder_test.sv
`timescale 1ns/1ps
module flash_code_encoder_test;
  localparam int BITS = 3;
  localparam int LEVELS = (1 << BITS) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              gray_sel = 1'b1;
  logic [LEVELS-1:0] therm_in = '1;
  logic [BITS-1:0]   code_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  flash_code_encoder #(.BITS(BITS)) uut (
    .clk(clk), .rst_n(rst_n), .gray_sel(gray_sel),
    .therm_in(therm_in), .code_out(code_out));

  always #5 clk = ~clk;

  // {mode, thermometer, expected}
  localparam logic [LEVELS+BITS:0] VEC [6] = '{
    {1'b1, 7'h7F, 3'd7},
    {1'b1, 7'h3F, 3'd6},
    {1'b1, 7'h00, 3'd0},
    {1'b0, 7'h0F, 3'd4},
    {1'b0, 7'h77, 3'd7},
    {1'b0, 7'h1B, 3'd5}
  };

  bit            p1_v, p2_v;
  logic [BITS-1:0] p1_e, p2_e;
  string         p1_r, p2_r;

  task automatic check(input logic [BITS-1:0] exp, input string rq);
    total++;
    if (code_out !== exp) begin
      bad++;
      $display("FAIL %s: code_out=%0d expected=%0d", rq, code_out, exp);
    end
  endtask

  task automatic push(input logic [LEVELS-1:0] t, input logic m,
                      input logic [BITS-1:0] e, input string rq, input bit v);
    @(negedge clk);
    if (p2_v) check(p2_e, p2_r);
    p2_v = p1_v; p2_e = p1_e; p2_r = p1_r;
    p1_v = v;    p1_e = e;    p1_r = rq;
    therm_in = t;
    gray_sel = m;
  endtask

  task automatic flush();
    push('0, 1'b0, '0, "", 1'b0);
    push('0, 1'b0, '0, "", 1'b0);
  endtask

  function automatic logic [LEVELS-1:0] clean(input int c);
    return LEVELS'((1 << c) - 1);
  endfunction

  function automatic int to_gray(input int c);
    return c ^ (c >> 1);
  endfunction

  function automatic int from_gray(input int g);
    int b = 0;
    for (int s = g; s != 0; s = s >> 1) b = b ^ s;
    return b;
  endfunction

  function automatic int tz(input int p);
    int n = 0;
    while (((p >> n) & 1) == 0) n++;
    return n;
  endfunction

  function automatic int voted_exp(input int c, input int p);
    int d = p - c;
    if (d == -1 || d == 0) return c - 1;
    if (d == 1 || d == 2)  return c + 1;
    return c;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: code_out=%0d expected=finished", code_out);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    p1_v = 0; p2_v = 0;
    repeat (3) @(negedge clk);
    check('0, "R1 held in reset");
    rst_n = 1'b1;

    foreach (VEC[i])
      push(VEC[i][LEVELS+BITS-1:BITS], VEC[i][LEVELS+BITS], VEC[i][BITS-1:0],
           VEC[i][LEVELS+BITS] ? "R4 table" : "R3/R5 table", 1'b1);
    flush();

    for (int c = 0; c <= LEVELS; c++) begin
      push(clean(c), 1'b0, BITS'(c), "R3", 1'b1);
      push(clean(c), 1'b1, BITS'(c), "R4", 1'b1);
    end
    flush();

    for (int c = 0; c <= LEVELS; c++)
      for (int p = 1; p <= LEVELS; p++) begin
        logic [LEVELS-1:0] pat;
        pat = clean(c) ^ LEVELS'(1 << (p - 1));
        push(pat, 1'b0, BITS'(voted_exp(c, p)), "R5", 1'b1);
        push(pat, 1'b1, BITS'(from_gray(to_gray(c) ^ (1 << tz(p)))), "R6", 1'b1);
      end
    flush();

    for (int c = 0; c <= LEVELS; c++)
      push(clean(c), c[0], BITS'(c), "R7 alternating route", 1'b1);
    flush();

    // R2: latency of two edges
    @(negedge clk);
    therm_in = clean(5); gray_sel = 1'b1;
    @(negedge clk);
    check(3'd0, "R2 one edge, still old");
    @(negedge clk);
    check(3'd5, "R2 two edges");

    // R1: asynchronous reset mid-stream
    therm_in = '1;
    repeat (2) @(negedge clk);
    check(3'd7, "R1 before reset");
    #2 rst_n = 1'b0;
    #1 check('0, "R1 async clear");
    @(negedge clk);
    check('0, "R1 held");
    rst_n = 1'b1;
    p1_v = 0; p2_v = 0;
    push(clean(2), 1'b0, 3'd2, "R3 after reset", 1'b1);
    flush();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule